// File: doc/BRIEF.md
# Binary32 Divide Special-Operand Resolver

This block sits in front of a single-precision floating-point divider. It looks at the two operands of each division request and decides whether the quotient is fixed by the operand classes alone. That is the case for NaN inputs, zeros and infinities. When it is, the block produces the final result and the invalid and divide-by-zero flags itself, and it raises a bypass indication. When both operands are finite and nonzero, bypass stays low. The operands and the quotient sign then go out to a downstream mantissa datapath.

Each operand is sorted into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. The resolver then tests the cases in a fixed priority order. NaNs come first, then the indeterminate forms 0/0 and inf/inf, then an infinite or zero dividend, then a zero divisor, then an infinite divisor. Because the dividend test comes before the divisor-zero test, an infinite dividend over zero never raises divide-by-zero. All outputs are registered and appear one clock after the input strobe.

Top module: `fdiv_special`

## Requirements
- R1: Outputs are registered. `out_valid_o` is high exactly in the cycle after a cycle where `in_valid_i` was high. The other outputs update only on valid inputs. After reset all outputs are 0.
- R2: If either operand is a NaN, the result is a NaN with bypass set and divide-by-zero clear. A NaN is an exponent of 0xFF with a nonzero fraction; bit 22 set marks it quiet, bit 22 clear marks it signaling. The result is the dividend if the dividend is a NaN, otherwise the divisor, with bit 22 forced to 1 in either case. Invalid is raised only if at least one operand is a signaling NaN.
- R3: 0/0 and inf/inf, with either sign, return 0x7FC00000 with invalid set, divide-by-zero clear and bypass set.
- R4: An infinite or zero dividend with a non-NaN divisor returns the dividend's class, with no flags and bypass set. This covers inf/0, whose result is an infinity with divide-by-zero clear.
- R5: A finite nonzero dividend (normal or subnormal) over a zero divisor returns an infinity (exponent 0xFF, fraction 0) and raises divide-by-zero, with invalid clear.
- R6: A finite dividend over an infinite divisor returns a zero with no flags and bypass set.
- R7: The sign bit of every non-NaN result is the XOR of the two operand sign bits (bit 31).
- R8: When both operands are finite and nonzero, bypass is low, both flags are clear, and `fin_a_o`, `fin_b_o` and `fin_sign_o` carry the operands and the XOR sign. Subnormals count as finite nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Request strobe |
| op_a_i | input | 32 | Dividend, binary32 |
| op_b_i | input | 32 | Divisor, binary32 |
| out_valid_o | output | 1 | Registered result valid |
| bypass_o | output | 1 | Result resolved without the mantissa divide |
| result_o | output | 32 | Special-case quotient |
| invalid_o | output | 1 | Invalid-operation flag |
| div_zero_o | output | 1 | Divide-by-zero flag |
| fin_a_o | output | 32 | Dividend forwarded to the finite datapath |
| fin_b_o | output | 32 | Divisor forwarded to the finite datapath |
| fin_sign_o | output | 1 | Quotient sign forwarded to the finite datapath |

## Verification
The riskiest error is a wrong ordering of the priority checks. It shows at the ports as a stray divide-by-zero on inf/0 or 0/0, or as a wrong default NaN. It appears in the very next output cycle, so every special pairing is driven with both signs and compared against the expected result on that cycle. A misclassified subnormal or NaN shows up as a wrong bypass decision on the same cycle. Back-to-back requests also check that each result lines up with its own request.

// File: rtl/fdiv_special_pkg.sv
package fdiv_special_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned FP_W   = 1 + EXP_W + FRAC_W;
  localparam logic [FP_W-1:0] DEFAULT_NAN = 32'h7FC0_0000;

  typedef enum logic [2:0] {
    CLS_ZERO, CLS_SUB, CLS_NORM, CLS_INF, CLS_QNAN, CLS_SNAN
  } fp_cls_e;
endpackage

// File: rtl/fp_classify.sv
module fp_classify
  import fdiv_special_pkg::*;
(
  input  logic [FP_W-1:0] op_i,
  output fp_cls_e         cls_o
);
  localparam int unsigned QBIT = FRAC_W - 1;
  logic [EXP_W-1:0]  exp_w;
  logic [FRAC_W-1:0] frac_w;
  assign exp_w  = op_i[FP_W-2 -: EXP_W];
  assign frac_w = op_i[FRAC_W-1:0];

  always_comb begin
    if (exp_w == '0)
      cls_o = (frac_w == '0) ? CLS_ZERO : CLS_SUB;
    else if (exp_w == '1) begin
      if (frac_w == '0)      cls_o = CLS_INF;
      else if (frac_w[QBIT]) cls_o = CLS_QNAN;
      else                   cls_o = CLS_SNAN;
    end else
      cls_o = CLS_NORM;
  end
endmodule

// File: rtl/fdiv_resolve.sv
module fdiv_resolve
  import fdiv_special_pkg::*;
(
  input  logic [FP_W-1:0] op_a_i,
  input  logic [FP_W-1:0] op_b_i,
  input  fp_cls_e         cls_a_i,
  input  fp_cls_e         cls_b_i,
  output logic            bypass_o,
  output logic [FP_W-1:0] result_o,
  output logic            invalid_o,
  output logic            div_zero_o,
  output logic            sign_o
);
  localparam int unsigned QBIT = FRAC_W - 1;
  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;

  assign a_nan  = (cls_a_i == CLS_QNAN) || (cls_a_i == CLS_SNAN);
  assign b_nan  = (cls_b_i == CLS_QNAN) || (cls_b_i == CLS_SNAN);
  assign a_inf  = cls_a_i == CLS_INF;
  assign b_inf  = cls_b_i == CLS_INF;
  assign a_zero = cls_a_i == CLS_ZERO;
  assign b_zero = cls_b_i == CLS_ZERO;
  assign sign_o = op_a_i[FP_W-1] ^ op_b_i[FP_W-1];

  // fixed priority: nan, indeterminate, special dividend, zero divisor, inf divisor
  always_comb begin
    bypass_o   = 1'b1;
    result_o   = '0;
    invalid_o  = 1'b0;
    div_zero_o = 1'b0;
    if (a_nan || b_nan) begin
      result_o       = a_nan ? op_a_i : op_b_i;
      result_o[QBIT] = 1'b1;
      invalid_o      = (cls_a_i == CLS_SNAN) || (cls_b_i == CLS_SNAN);
    end else if ((a_zero && b_zero) || (a_inf && b_inf)) begin
      result_o  = DEFAULT_NAN;
      invalid_o = 1'b1;
    end else if (a_inf || a_zero) begin
      result_o = {sign_o, op_a_i[FP_W-2:0]};
    end else if (b_zero) begin
      result_o   = {sign_o, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      div_zero_o = 1'b1;
    end else if (b_inf) begin
      result_o = {sign_o, {(FP_W-1){1'b0}}};
    end else begin
      bypass_o = 1'b0;
    end
  end
endmodule

// File: rtl/fdiv_special.sv
module fdiv_special
  import fdiv_special_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [31:0] op_a_i,
  input  logic [31:0] op_b_i,
  output logic        out_valid_o,
  output logic        bypass_o,
  output logic [31:0] result_o,
  output logic        invalid_o,
  output logic        div_zero_o,
  output logic [31:0] fin_a_o,
  output logic [31:0] fin_b_o,
  output logic        fin_sign_o
);
  fp_cls_e cls_a, cls_b;
  logic byp_c, inv_c, dz_c, sgn_c;
  logic [FP_W-1:0] res_c;

  fp_classify u_cls_a (.op_i(op_a_i), .cls_o(cls_a));
  fp_classify u_cls_b (.op_i(op_b_i), .cls_o(cls_b));

  fdiv_resolve u_res (
    .op_a_i(op_a_i), .op_b_i(op_b_i), .cls_a_i(cls_a), .cls_b_i(cls_b),
    .bypass_o(byp_c), .result_o(res_c), .invalid_o(inv_c),
    .div_zero_o(dz_c), .sign_o(sgn_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      bypass_o    <= 1'b0;
      result_o    <= '0;
      invalid_o   <= 1'b0;
      div_zero_o  <= 1'b0;
      fin_a_o     <= '0;
      fin_b_o     <= '0;
      fin_sign_o  <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        bypass_o   <= byp_c;
        result_o   <= res_c;
        invalid_o  <= inv_c;
        div_zero_o <= dz_c;
        fin_a_o    <= op_a_i;
        fin_b_o    <= op_b_i;
        fin_sign_o <= sgn_c;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i));
  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(in_valid_i) |-> $stable(result_o) && $stable(bypass_o));
  // R5
  dz_finite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_o |-> bypass_o && !invalid_o && result_o[30:0] == 31'h7F80_0000);
  // R4
  inf_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && fin_a_o[30:0] == 31'h7F80_0000 && fin_b_o[30:0] == 31'h0) |-> !div_zero_o);
  // R8
  finite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !bypass_o) |-> !invalid_o && !div_zero_o &&
      fin_sign_o == (fin_a_o[31] ^ fin_b_o[31]));
  // R3
  indet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && fin_a_o[30:0] == 31'h0 && fin_b_o[30:0] == 31'h0) |->
      invalid_o && result_o == DEFAULT_NAN);
endmodule

// File: tb/tb_fdiv_special.sv
module tb_fdiv_special;
  logic clk = 1'b0, rst_ni = 1'b0, in_valid = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic out_valid, bypass, invalid, dz, fsign;
  logic [31:0] result, fa, fb;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [31:0] res; logic byp, inv, dz, sgn; logic [31:0] a, b; logic [7:0] req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  fdiv_special dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .op_a_i(a), .op_b_i(b),
    .out_valid_o(out_valid), .bypass_o(bypass), .result_o(result),
    .invalid_o(invalid), .div_zero_o(dz), .fin_a_o(fa), .fin_b_o(fb), .fin_sign_o(fsign)
  );

  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] PI = 32'h7F80_0000, NI = 32'hFF80_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000, NTWO = 32'hC000_0000, SUB = 32'h0000_0001;
  localparam logic [31:0] QN = 32'h7FC0_1234, SN = 32'hFFA0_0055, DN = 32'h7FC0_0000;

  task automatic push(input logic [31:0] x, input logic [31:0] y, input logic [31:0] r,
                      input logic byp, input logic inv, input logic z, input logic [7:0] req);
    exp_t e;
    e.res = r; e.byp = byp; e.inv = inv; e.dz = z; e.sgn = x[31] ^ y[31];
    e.a = x; e.b = y; e.req = req;
    q.push_back(e);
    @(negedge clk); a = x; b = y; in_valid = 1'b1;
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp, input logic [7:0] req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_ni && out_valid) begin
    exp_t e;
    if (q.size() == 0) chk("unexpected valid", 32'd1, 32'd0, 8'd1);
    else begin
      e = q.pop_front();
      chk("bypass", {31'b0, bypass}, {31'b0, e.byp}, e.req);
      chk("invalid", {31'b0, invalid}, {31'b0, e.inv}, e.req);
      chk("div_zero", {31'b0, dz}, {31'b0, e.dz}, e.req);
      if (e.byp) chk("result", result, e.res, e.req);
      else begin
        chk("fin_a", fa, e.a, 8);
        chk("fin_b", fb, e.b, 8);
        chk("fin_sign", {31'b0, fsign}, {31'b0, e.sgn}, 8);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("reset valid", {31'b0, out_valid}, 32'd0, 1);
    chk("reset result", result, 32'd0, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("idle valid", {31'b0, out_valid}, 32'd0, 1);
    // R2 NaN handling
    push(QN, ONE, QN, 1, 0, 0, 2);
    push(ONE, SN, 32'hFFE0_0055, 1, 1, 0, 2);
    push(SN, QN, 32'hFFE0_0055, 1, 1, 0, 2);
    push(PZ, QN, QN, 1, 0, 0, 2);
    // R3 indeterminate
    push(PZ, NZ, DN, 1, 1, 0, 3);
    push(NI, PI, DN, 1, 1, 0, 3);
    // R4 special dividend, R7 sign
    push(NI, PZ, NI, 1, 0, 0, 4);
    push(PI, NZ, NI, 1, 0, 0, 7);
    push(NZ, ONE, NZ, 1, 0, 0, 4);
    push(PZ, NI, NZ, 1, 0, 0, 7);
    push(NI, NTWO, PI, 1, 0, 0, 4);
    // R5 divide by zero
    push(ONE, NZ, NI, 1, 0, 1, 5);
    push(SUB, PZ, PI, 1, 0, 1, 5);
    push(NTWO, NZ, PI, 1, 0, 1, 7);
    // R6 divide by infinity
    push(NTWO, PI, NZ, 1, 0, 0, 6);
    push(SUB, NI, NZ, 1, 0, 0, 6);
    // R8 finite pass-through
    push(ONE, NTWO, 32'h0, 0, 0, 0, 8);
    push(SUB, ONE, 32'h0, 0, 0, 0, 8);
    @(negedge clk); in_valid = 1'b0; a = PI; b = PZ;
    @(negedge clk);
    // R1 hold while idle
    chk("idle valid after burst", {31'b0, out_valid}, 32'd0, 1);
    chk("hold bypass", {31'b0, bypass}, 32'd0, 1);
    chk("queue drained", q.size(), 0, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule